// File: doc/BRIEF.md
# Per-Core Local Interrupt Router with Doorbell Mailboxes

This block sits beside a cluster of four processor cores and decides, for each core, whether its single IRQ line is raised. Every core owns four level-sensitive timer inputs and four 32-bit doorbell mailboxes. A flag from a shared peripheral interrupt controller, which reports that the controller has something pending, is also merged in. That flag goes to core 0 only. For each core, two 8-bit control registers pick which timers and which mailboxes may drive the IRQ line. The upper nibble of each control register records a fast-interrupt choice, and a source marked that way is kept off the IRQ line. The fast-interrupt output itself is not generated here.

Each core has its own 32-bit register port, so the block has four ports, and any port can reach any core's registers. A mailbox is written through two separate addresses. Writing a mask to the set address ORs the mask into the mailbox, and writing a mask to the clear address clears the bits that are 1 in the mask. A read of the clear address returns the mailbox contents, which lets a core send a doorbell to another core and the receiver acknowledge it. A mailbox raises its core's IRQ for as long as it holds any nonzero bit and is enabled.

Top module: `core_irq_router`

## Requirements
- R1: A synchronous active-high reset clears all control registers and mailboxes. After reset, every IRQ output is low and every register reads zero.
- R2: Timer control bits 3:0 enable timer inputs 3:0 onto the core's IRQ. The IRQ follows the enabled timer levels in the same cycle, with no latching.
- R3: Bits 7:4 of both control registers are fast-interrupt choices and read back as written. A source whose choice bit is 1 does not drive the IRQ and does not show in the pending register, even when its enable bit is set.
- R4: A write to mailbox m's set address of core c ORs the write data into that mailbox. Other mailboxes are untouched.
- R5: A read of a mailbox clear address returns the mailbox contents. A write there clears the bits that are 1 in the data. A read of a set address returns zero.
- R6: Mailbox m raises its core's IRQ while the mailbox is nonzero and mailbox-control bit m is 1 (with bit m+4 equal to 0). The level persists until the mailbox is cleared.
- R7: The shared-controller pending flag drives core 0's IRQ and no other core's.
- R8: The pending register of a core is read-only. Bits 3:0 are the routed timers, bits 7:4 are the routed mailboxes 3:0, and bit 8 is the shared-controller flag (core 0 only). All other bits read zero.
- R9: All four ports may address any core's mailboxes in the same cycle. Set masks from several ports merge by OR, and in a bit that is both set and cleared in one cycle, the set wins.
- R10: When several ports write the same control register in one cycle, the lowest-numbered port's data is stored.
- R11: The address decode uses byte address bits [7:4] as the region and bits [3:2] as the core index, and ignores bits [1:0]. Region 0x0 is timer control, 0x1 is mailbox control and 0x2 is pending. Regions 0x8+m are the set addresses and 0xC+m are the clear addresses of mailbox m. Regions 0x3 to 0x7 read zero and ignore writes, and so do writes to pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr | input | 4 | Write strobe, one per port |
| bus_rd | input | 4 | Read strobe, one per port |
| bus_addr | input | 32 | Byte address, 8 bits per port |
| bus_wdata | input | 128 | Write data, 32 bits per port |
| bus_rdata | output | 128 | Read data, 32 bits per port, valid in the cycle of the read strobe |
| timer_irq | input | 16 | Timer levels, 4 per core, core c at bits 4c+3:4c |
| shared_pend | input | 1 | Shared peripheral controller has a pending interrupt |
| irq_o | output | 4 | IRQ line per core |

## Verification
The hardest situation to reach is several ports touching one mailbox or one control register in the same clock cycle: a set from one core, a set from a second core and a clear from a third all landing together. Normal single-port traffic never produces it. The bench reaches it by driving several port strobes within one cycle before the capturing edge. It then reads the result back through a clear address or a control address, which shows the OR merge, the set-over-clear rule and the lowest-port priority directly at the ports.

// File: rtl/cir_pkg.sv
package cir_pkg;

    localparam int CIR_CORES  = 4;
    localparam int CIR_TIMERS = 4;
    localparam int CIR_MBOXES = 4;
    localparam int CIR_DW     = 32;
    localparam int CIR_AW     = 8;
    localparam int CIR_RGN_W  = 4;

    localparam logic [CIR_RGN_W-1:0] RGN_TCTL = 4'h0;
    localparam logic [CIR_RGN_W-1:0] RGN_MCTL = 4'h1;
    localparam logic [CIR_RGN_W-1:0] RGN_PEND = 4'h2;

    // Decoded target of one bus access
    typedef struct packed {
        logic       tctl;
        logic       mctl;
        logic       pend;
        logic       mset;
        logic       mclr;
        logic [1:0] mbox;
    } cir_sel_t;

    function automatic cir_sel_t cir_region(input logic [CIR_RGN_W-1:0] rgn,
                                            input logic act);
        cir_sel_t s;
        s      = '0;
        s.mbox = rgn[1:0];
        if (act) begin
            if (rgn[3]) begin
                s.mset = !rgn[2];
                s.mclr = rgn[2];
            end else begin
                s.tctl = (rgn == RGN_TCTL);
                s.mctl = (rgn == RGN_MCTL);
                s.pend = (rgn == RGN_PEND);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/cir_decode.sv
module cir_decode
    import cir_pkg::*;
#(
    parameter int ADDR_W = CIR_AW,
    parameter int CORE_W = 2
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output cir_sel_t          wsel_o,
    output cir_sel_t          rsel_o,
    output logic [CORE_W-1:0] core_o
);

    logic [CIR_RGN_W-1:0] rgn;
    logic                 unused_lsb;

    assign rgn        = addr_i[ADDR_W-1 -: CIR_RGN_W];
    assign core_o     = addr_i[2 +: CORE_W];
    assign wsel_o     = cir_region(rgn, wr_i);
    assign rsel_o     = cir_region(rgn, rd_i);
    assign unused_lsb = ^addr_i[1:0];

    generate
        if (ADDR_W > CIR_RGN_W + CORE_W + 2) begin : g_gap
            logic unused_gap;
            assign unused_gap = ^addr_i[ADDR_W-CIR_RGN_W-1:2+CORE_W];
        end
    endgenerate

endmodule

// File: rtl/cir_ctrl_reg.sv
module cir_ctrl_reg #(
    parameter int NP = 4,
    parameter int W  = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NP-1:0]   hit_i,
    input  logic [NP*W-1:0] data_i,
    output logic [W-1:0]    q_o
);

    logic [W-1:0] nxt;

    // Highest index first so the lowest-numbered port is applied last
    always_comb begin
        nxt = q_o;
        for (int p = NP - 1; p >= 0; p--) begin
            if (hit_i[p]) nxt = data_i[p*W +: W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q_o <= '0;
        else       q_o <= nxt;
    end

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (q_o == '0));

    p_low_port_wins_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_i[0] |=> (q_o == $past(data_i[W-1:0])));

    p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_i == '0) |=> $stable(q_o));

endmodule

// File: rtl/cir_mailbox.sv
module cir_mailbox #(
    parameter int NP = 4,
    parameter int DW = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NP-1:0]    set_hit_i,
    input  logic [NP-1:0]    clr_hit_i,
    input  logic [NP*DW-1:0] data_i,
    output logic [DW-1:0]    q_o
);

    logic [DW-1:0] set_mask;
    logic [DW-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int p = 0; p < NP; p++) begin
            if (set_hit_i[p]) set_mask = set_mask | data_i[p*DW +: DW];
            if (clr_hit_i[p]) clr_mask = clr_mask | data_i[p*DW +: DW];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q_o <= '0;
        else       q_o <= (q_o & ~clr_mask) | set_mask;
    end

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (q_o == '0));

    p_set_lands_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (|set_mask) |=> ((q_o & $past(set_mask)) == $past(set_mask)));

    p_clear_drops_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (|clr_mask) |=> ((q_o & $past(clr_mask) & ~$past(set_mask)) == '0));

    p_set_beats_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(set_mask & clr_mask)) |=>
            ((q_o & $past(set_mask & clr_mask)) == $past(set_mask & clr_mask)));

    p_quiet_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ((set_mask == '0) && (clr_mask == '0)) |=> $stable(q_o));

endmodule

// File: rtl/cir_route.sv
module cir_route #(
    parameter int NT      = 4,
    parameter int NM      = 4,
    parameter bit PRIMARY = 1'b0
) (
    input  logic [NT-1:0]     timer_i,
    input  logic [2*NT-1:0]   tctl_i,
    input  logic [2*NM-1:0]   mctl_i,
    input  logic [NM-1:0]     live_i,
    input  logic              shared_i,
    output logic [NT+NM:0]    pend_o,
    output logic              irq_o
);

    logic [NT-1:0] t_route;
    logic [NM-1:0] m_route;
    logic          s_route;

    // A source marked for the fast-interrupt path stays off the IRQ line
    assign t_route = timer_i & tctl_i[NT-1:0] & ~tctl_i[2*NT-1:NT];
    assign m_route = live_i  & mctl_i[NM-1:0] & ~mctl_i[2*NM-1:NM];

    generate
        if (PRIMARY) begin : g_primary
            assign s_route = shared_i;
        end else begin : g_secondary
            logic unused_shared;
            assign unused_shared = shared_i;
            assign s_route       = 1'b0;
        end
    endgenerate

    assign pend_o = {s_route, m_route, t_route};
    assign irq_o  = |pend_o;

endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
    import cir_pkg::*;
#(
    parameter int NUM_CORES  = CIR_CORES,
    parameter int NUM_TIMERS = CIR_TIMERS,
    parameter int NUM_MBOX   = CIR_MBOXES,
    parameter int DATA_W     = CIR_DW,
    parameter int ADDR_W     = CIR_AW
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [NUM_CORES-1:0]        bus_wr,
    input  logic [NUM_CORES-1:0]        bus_rd,
    input  logic [NUM_CORES*ADDR_W-1:0] bus_addr,
    input  logic [NUM_CORES*DATA_W-1:0] bus_wdata,
    output logic [NUM_CORES*DATA_W-1:0] bus_rdata,
    input  logic [NUM_CORES*NUM_TIMERS-1:0] timer_irq,
    input  logic                        shared_pend,
    output logic [NUM_CORES-1:0]        irq_o
);

    localparam int NP = NUM_CORES;
    localparam int CW = $clog2(NUM_CORES);
    localparam int NT = NUM_TIMERS;
    localparam int NM = NUM_MBOX;
    localparam int TW = 2 * NT;
    localparam int MW = 2 * NM;
    localparam int PW = NT + NM + 1;

    cir_sel_t        wsel [NP];
    cir_sel_t        rsel [NP];
    logic [CW-1:0]   tgt  [NP];

    logic [NP*TW-1:0] tdata;
    logic [NP*MW-1:0] mdata;

    logic [NP-1:0]   tctl_hit [NUM_CORES];
    logic [NP-1:0]   mctl_hit [NUM_CORES];
    logic [NP-1:0]   set_hit  [NUM_CORES][NM];
    logic [NP-1:0]   clr_hit  [NUM_CORES][NM];

    logic [TW-1:0]     tctl_q    [NUM_CORES];
    logic [MW-1:0]     mctl_q    [NUM_CORES];
    logic [DATA_W-1:0] mbox_q    [NUM_CORES][NM];
    logic [NM-1:0]     mbox_live [NUM_CORES];
    logic [PW-1:0]     pend_q    [NUM_CORES];
    logic [DATA_W-1:0] rdata     [NP];

    // ---------------- per-port decode ----------------
    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            logic unused_sel;
            cir_decode #(
                .ADDR_W (ADDR_W),
                .CORE_W (CW)
            ) u_dec (
                .wr_i   (bus_wr[p]),
                .rd_i   (bus_rd[p]),
                .addr_i (bus_addr[p*ADDR_W +: ADDR_W]),
                .wsel_o (wsel[p]),
                .rsel_o (rsel[p]),
                .core_o (tgt[p])
            );
            // pending is read-only and set addresses read as zero
            assign unused_sel = wsel[p].pend ^ rsel[p].mset;
            assign bus_rdata[p*DATA_W +: DATA_W] = rdata[p];
        end
    endgenerate

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            tdata[p*TW +: TW] = bus_wdata[p*DATA_W +: TW];
            mdata[p*MW +: MW] = bus_wdata[p*DATA_W +: MW];
        end
    end

    // ---------------- target selection ----------------
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            for (int p = 0; p < NP; p++) begin
                tctl_hit[c][p] = wsel[p].tctl && (tgt[p] == CW'(c));
                mctl_hit[c][p] = wsel[p].mctl && (tgt[p] == CW'(c));
                for (int m = 0; m < NM; m++) begin
                    set_hit[c][m][p] = wsel[p].mset && (tgt[p] == CW'(c))
                                       && (wsel[p].mbox == 2'(m));
                    clr_hit[c][m][p] = wsel[p].mclr && (tgt[p] == CW'(c))
                                       && (wsel[p].mbox == 2'(m));
                end
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            for (int m = 0; m < NM; m++) begin
                mbox_live[c][m] = |mbox_q[c][m];
            end
        end
    end

    // ---------------- per-core state and routing ----------------
    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            cir_ctrl_reg #(.NP(NP), .W(TW)) u_tctl (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .hit_i  (tctl_hit[c]),
                .data_i (tdata),
                .q_o    (tctl_q[c])
            );

            cir_ctrl_reg #(.NP(NP), .W(MW)) u_mctl (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .hit_i  (mctl_hit[c]),
                .data_i (mdata),
                .q_o    (mctl_q[c])
            );

            for (genvar m = 0; m < NM; m++) begin : g_mbox
                cir_mailbox #(.NP(NP), .DW(DATA_W)) u_mbox (
                    .clk_i     (clk_i),
                    .rst_i     (rst_i),
                    .set_hit_i (set_hit[c][m]),
                    .clr_hit_i (clr_hit[c][m]),
                    .data_i    (bus_wdata),
                    .q_o       (mbox_q[c][m])
                );
            end

            cir_route #(.NT(NT), .NM(NM), .PRIMARY(c == 0)) u_route (
                .timer_i  (timer_irq[c*NT +: NT]),
                .tctl_i   (tctl_q[c]),
                .mctl_i   (mctl_q[c]),
                .live_i   (mbox_live[c]),
                .shared_i (shared_pend),
                .pend_o   (pend_q[c]),
                .irq_o    (irq_o[c])
            );

            p_timer_raises_r2: assert property (@(posedge clk_i) disable iff (rst_i)
                (|(timer_irq[c*NT +: NT] & tctl_q[c][NT-1:0] & ~tctl_q[c][TW-1:NT]))
                    |-> irq_o[c]);

            p_quiet_without_source_r6: assert property (@(posedge clk_i) disable iff (rst_i)
                (((timer_irq[c*NT +: NT] & tctl_q[c][NT-1:0] & ~tctl_q[c][TW-1:NT]) == '0)
                 && ((mbox_live[c] & mctl_q[c][NM-1:0] & ~mctl_q[c][MW-1:NM]) == '0)
                 && !((c == 0) && shared_pend))
                    |-> !irq_o[c]);

            if (c == 0) begin : g_shared_chk
                p_shared_core0_r7: assert property (@(posedge clk_i) disable iff (rst_i)
                    shared_pend |-> irq_o[0]);
            end
        end
    endgenerate

    // ---------------- read return ----------------
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            rdata[p] = '0;
            if (rsel[p].tctl) rdata[p][TW-1:0] = tctl_q[tgt[p]];
            if (rsel[p].mctl) rdata[p][MW-1:0] = mctl_q[tgt[p]];
            if (rsel[p].pend) rdata[p][PW-1:0] = pend_q[tgt[p]];
            if (rsel[p].mclr) rdata[p]         = mbox_q[tgt[p]][rsel[p].mbox];
        end
    end

endmodule

// File: tb/tb_core_irq_router.sv
`timescale 1ns/1ps
module tb_core_irq_router;

    localparam int NC = 4;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NT = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NC-1:0]    bus_wr    = '0;
    logic [NC-1:0]    bus_rd    = '0;
    logic [NC*AW-1:0] bus_addr  = '0;
    logic [NC*DW-1:0] bus_wdata = '0;
    logic [NC*DW-1:0] bus_rdata;
    logic [NC*NT-1:0] timer_irq = '0;
    logic             shared_pend = 1'b0;
    logic [NC-1:0]    irq_o;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    core_irq_router dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .timer_irq   (timer_irq),
        .shared_pend (shared_pend),
        .irq_o       (irq_o)
    );

    function automatic logic [7:0] ad(int rgn, int core);
        return {rgn[3:0], core[1:0], 2'b00};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = '0; bus_rd = '0; bus_addr = '0; bus_wdata = '0;
        timer_irq = '0; shared_pend = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put(int p, logic [7:0] a, logic [31:0] d);
        bus_wr[p] = 1'b1;
        bus_addr[p*AW +: AW] = a;
        bus_wdata[p*DW +: DW] = d;
    endtask

    task automatic wr1(int p, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        put(p, a, d);
        @(negedge clk);
        bus_wr = '0;
    endtask

    task automatic rd1(int p, logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd[p] = 1'b1;
        bus_addr[p*AW +: AW] = a;
        #1;
        v = bus_rdata[p*DW +: DW];
        bus_rd[p] = 1'b0;
    endtask

    task automatic set_timer(int c, logic [3:0] v);
        @(negedge clk);
        timer_irq[c*NT +: NT] = v;
        #1;
    endtask

    // R1: reset clears everything written before it
    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        wr1(0, ad(0, 0), 32'hFF);
        wr1(1, ad(8, 1), 32'h1234);
        wr1(2, ad(1, 1), 32'h0F);
        do_reset();
        #1;
        chk("R1 irq after reset", 32'(irq_o), 32'h0);
        rd1(0, ad(0, 0), v);  chk("R1 timer ctrl core0", v, 32'h0);
        rd1(3, ad(1, 1), v);  chk("R1 mbox ctrl core1", v, 32'h0);
        rd1(2, ad(12, 1), v); chk("R1 mailbox0 core1", v, 32'h0);
        rd1(0, ad(2, 0), v);  chk("R1 pending core0", v, 32'h0);
    endtask

    // R2: timer enables route level inputs combinationally
    task automatic t_timer();
        logic [31:0] v;
        do_reset();
        wr1(0, ad(0, 1), 32'h05);
        set_timer(1, 4'b0010);
        chk("R2 disabled timer1 keeps irq low", 32'(irq_o[1]), 32'h0);
        set_timer(1, 4'b0100);
        chk("R2 enabled timer2 raises irq1", 32'(irq_o[1]), 32'h1);
        rd1(1, ad(2, 1), v);
        chk("R2 pending core1 timer bit", v, 32'h4);
        set_timer(2, 4'b1111);
        chk("R2 core2 without enables stays low", 32'(irq_o[2]), 32'h0);
        set_timer(1, 4'b0000);
        chk("R2 irq1 drops with timer level", 32'(irq_o[1]), 32'h0);
    endtask

    // R3: fast-interrupt choice bits are stored and keep sources off IRQ
    task automatic t_fiq();
        logic [31:0] v;
        do_reset();
        wr1(0, ad(0, 1), 32'h44);
        rd1(0, ad(0, 1), v);
        chk("R3 timer ctrl readback", v, 32'h44);
        set_timer(1, 4'b0100);
        chk("R3 fiq-marked timer off irq", 32'(irq_o[1]), 32'h0);
        rd1(1, ad(2, 1), v);
        chk("R3 fiq-marked timer not pending", v, 32'h0);
        wr1(2, ad(1, 1), 32'h11);
        rd1(2, ad(1, 1), v);
        chk("R3 mbox ctrl readback", v, 32'h11);
        wr1(2, ad(8, 1), 32'h1);
        #1;
        chk("R3 fiq-marked mailbox off irq", 32'(irq_o[1]), 32'h0);
        wr1(2, ad(1, 1), 32'h01);
        #1;
        chk("R3 mailbox on irq once choice cleared", 32'(irq_o[1]), 32'h1);
    endtask

    // R4, R5: set ORs, clear read returns contents, clear write drops bits
    task automatic t_mbox();
        logic [31:0] v;
        do_reset();
        wr1(0, ad(8, 2), 32'h0000_00F0);
        wr1(0, ad(8, 2), 32'h0000_0F00);
        rd1(0, ad(12, 2), v);
        chk("R4 set accumulates by OR", v, 32'h0000_0FF0);
        rd1(1, ad(15, 2), v);
        chk("R4 other mailbox untouched", v, 32'h0);
        rd1(0, ad(8, 2), v);
        chk("R5 set address reads zero", v, 32'h0);
        wr1(3, ad(12, 2), 32'h0000_0030);
        rd1(0, ad(12, 2), v);
        chk("R5 clear drops masked bits", v, 32'h0000_0FC0);
    endtask

    // R6: mailbox level interrupt
    task automatic t_mbox_irq();
        do_reset();
        wr1(0, ad(9, 2), 32'h8000_0000);
        #1;
        chk("R6 mailbox1 without enable", 32'(irq_o[2]), 32'h0);
        wr1(0, ad(1, 2), 32'h02);
        #1;
        chk("R6 enabled nonzero mailbox1 raises irq2", 32'(irq_o[2]), 32'h1);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 mailbox irq persists", 32'(irq_o[2]), 32'h1);
        wr1(2, ad(13, 2), 32'h8000_0000);
        #1;
        chk("R6 irq drops when mailbox empties", 32'(irq_o[2]), 32'h0);
    endtask

    // R7: shared flag only to core 0
    task automatic t_shared();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        shared_pend = 1'b1;
        #1;
        chk("R7 shared flag reaches only core0", 32'(irq_o), 32'h1);
        rd1(0, ad(2, 0), v); chk("R7 pending core0 bit8", v, 32'h100);
        rd1(1, ad(2, 1), v); chk("R7 pending core1 no bit8", v, 32'h0);
        @(negedge clk);
        shared_pend = 1'b0;
        #1;
        chk("R7 irq0 drops with flag", 32'(irq_o), 32'h0);
    endtask

    // R8: pending layout with all source kinds together
    task automatic t_pending();
        logic [31:0] v;
        do_reset();
        wr1(0, ad(0, 0), 32'h0F);
        wr1(0, ad(1, 0), 32'h0F);
        wr1(1, ad(10, 0), 32'h1);
        set_timer(0, 4'b1001);
        @(negedge clk);
        shared_pend = 1'b1;
        rd1(0, ad(2, 0), v);
        chk("R8 pending combined layout", v, 32'h149);
        wr1(0, ad(2, 0), 32'hFFFF_FFFF);
        rd1(0, ad(2, 0), v);
        chk("R8 pending ignores writes", v, 32'h149);
    endtask

    // R9: concurrent mailbox access from several ports
    task automatic t_cross();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        put(1, ad(8, 3), 32'h0F);
        put(2, ad(8, 3), 32'hF0);
        put(3, ad(12, 3), 32'hFF);
        @(negedge clk);
        bus_wr = '0;
        rd1(0, ad(12, 3), v);
        chk("R9 two sets merge and beat clear", v, 32'hFF);
        @(negedge clk);
        put(1, ad(12, 3), 32'h0F);
        put(0, ad(8, 3), 32'h01);
        @(negedge clk);
        bus_wr = '0;
        rd1(2, ad(12, 3), v);
        chk("R9 set bit survives same-cycle clear", v, 32'hF1);
        wr1(3, ad(1, 3), 32'h01);
        #1;
        chk("R9 doorbell raises target core", 32'(irq_o), 32'h8);
    endtask

    // R10: lowest port wins on the same control register
    task automatic t_prio();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        put(2, ad(0, 3), 32'h0A);
        put(1, ad(0, 3), 32'h03);
        put(3, ad(1, 0), 32'h22);
        put(0, ad(0, 0), 32'h11);
        @(negedge clk);
        bus_wr = '0;
        rd1(0, ad(0, 3), v); chk("R10 lowest port stored", v, 32'h03);
        rd1(0, ad(1, 0), v); chk("R10 distinct target lands", v, 32'h22);
        rd1(0, ad(0, 0), v); chk("R10 port0 own target lands", v, 32'h11);
    endtask

    // R11: region/core fields, ignored low bits, unmapped regions
    task automatic t_unmapped();
        logic [31:0] v;
        do_reset();
        wr1(0, ad(3, 0), 32'hFFFF_FFFF);
        wr1(0, ad(7, 0), 32'hFFFF_FFFF);
        wr1(1, ad(5, 1), 32'hFFFF_FFFF);
        rd1(0, ad(3, 0), v); chk("R11 unmapped region reads zero", v, 32'h0);
        rd1(0, ad(0, 0), v); chk("R11 timer ctrl untouched", v, 32'h0);
        rd1(0, ad(1, 0), v); chk("R11 mbox ctrl untouched", v, 32'h0);
        rd1(1, ad(12, 1), v); chk("R11 mailbox untouched", v, 32'h0);
        wr1(0, ad(0, 1) | 8'h03, 32'h01);
        rd1(2, ad(0, 1), v); chk("R11 low address bits ignored", v, 32'h01);
        rd1(2, ad(0, 2), v); chk("R11 core field selects core", v, 32'h0);
    endtask

    initial begin
        t_reset();
        t_timer();
        t_fiq();
        t_mbox();
        t_mbox_irq();
        t_shared();
        t_pending();
        t_cross();
        t_prio();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog act=timeout exp=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule